// File: doc/BRIEF.md
# Entropy Sample Collector

This block gathers raw entropy from a bank of free-running oscillators and turns it into a stream of 8-bit noise samples. On every clock while the run enable is high it reduces the enabled oscillator bits to one parity bit. It then XOR-folds a programmable number of those parity bits into a single folded bit, which it shifts into a byte register. Each completed byte is presented with a one-cycle valid strobe.

Bytes are counted in blocks of 512 bits, which is 64 bytes. A programmable number of blocks forms one group, and the block marks the last byte of each group with a one-cycle done pulse. A setting of zero for either the fold length or the group length selects that setting's largest count. Both settings can be loaded only while the block is stopped. Dropping the run enable discards any partial progress.

Top module: `entropy_sample_collector`

## Requirements
- R1: After reset, byteValid and groupDone are 0 and byteOut is 0. The fold length resets to 1 and the group length resets to 1 block.
- R2: On each clock edge with runEn high, one parity bit is taken: the XOR of the oscIn bits whose oscMask bit is 1. Sources whose mask bit is 0 have no effect, so an all-zero mask yields bytes of value 0.
- R3: Each shifted bit is the XOR of N consecutive parity bits, where N is the fold-length setting. A setting of 0 means N = 65536.
- R4: The folded bits enter the byte at bit 0 and move toward bit 7, so the first of eight bits ends in bit 7. byteOut takes its new value only with byteValid and holds it otherwise.
- R5: byteValid is high for exactly one cycle. It rises in the cycle after the edge that took the last parity bit of a byte's eighth folded bit.
- R6: Every 64 bytes complete one block. groupDone pulses for one cycle, together with byteValid, on the last byte of every G-th block, where G is the group-length setting and 0 means 256. Counting then restarts for the next group.
- R7: The two settings load from cfgSampleCycles and cfgNoiseBlocks on an edge where cfgWrEn is high and runEn is low. A write while runEn is high is ignored.
- R8: An edge with runEn low clears the fold, bit, byte and block progress and drives byteValid and groupDone low. When running resumes, a fresh byte and a fresh group start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run enable; low stops and clears progress |
| oscIn | input | NUM_OSC | Raw oscillator bits |
| oscMask | input | NUM_OSC | Per-oscillator enable |
| cfgWrEn | input | 1 | Settings load strobe, honoured only while stopped |
| cfgSampleCycles | input | CFG_W | Fold length, 0 = 65536 |
| cfgNoiseBlocks | input | CFG_W | Blocks per group, 0 = 256 |
| byteValid | output | 1 | One-cycle strobe for a new byte |
| byteOut | output | 8 | Most recent noise byte |
| groupDone | output | 1 | One-cycle pulse on the last byte of a group |

## Verification
The oscillator bits come from a pseudo-random source and are tried with four masks. An all-ones mask exercises the full parity tree. A single-bit mask shows that every other source is ignored. An alternating mask catches a wrong bit order in the reduction, and an all-zero mask must give zero bytes. Fold lengths of 1, 3 and 0 tell a correct fold count from an off-by-one count and from a wrong meaning for zero. Group lengths of 1, 2 and 0 do the same for block counting, and a write while running, plus a stop in the middle of a byte, separate ignored settings and discarded progress from retained ones.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef struct packed {
    logic clear;
    logic sample;
    logic foldLast;
    logic byteLast;
  } escStrobes_t;
endpackage

// File: rtl/esc_ctrl.sv
module esc_ctrl #(
  parameter int CFG_W = 8,
  parameter int FOLD_W = 16,
  parameter int BLOCK_BITS = 512,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic cfgWrEn,
  input  logic [CFG_W-1:0] cfgSampleCycles,
  input  logic [CFG_W-1:0] cfgNoiseBlocks,
  output esc_pkg::escStrobes_t strobes,
  output logic groupDone
);
  localparam int BYTES_PER_BLOCK = BLOCK_BITS / BYTE_W;
  localparam int BYTE_CNT_W = $clog2(BYTES_PER_BLOCK);
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  logic [CFG_W-1:0] sampleCycles;
  logic [CFG_W-1:0] noiseBlocks;
  logic [FOLD_W-1:0] foldCnt;
  logic [FOLD_W-1:0] foldLim;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_CNT_W-1:0] byteCnt;
  logic [CFG_W-1:0] blockCnt;
  logic [CFG_W-1:0] blockLim;
  logic blockLast;

  always_comb begin
    if (sampleCycles == '0) foldLim = '1;
    else foldLim = FOLD_W'(sampleCycles) - FOLD_W'(1);
    if (noiseBlocks == '0) blockLim = '1;
    else blockLim = noiseBlocks - CFG_W'(1);
  end

  always_comb begin
    strobes.clear = !runEn;
    strobes.sample = runEn;
    strobes.foldLast = runEn && (foldCnt == foldLim);
    strobes.byteLast = strobes.foldLast && (bitCnt == BIT_CNT_W'(BYTE_W - 1));
    blockLast = strobes.byteLast && (byteCnt == BYTE_CNT_W'(BYTES_PER_BLOCK - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCycles <= CFG_W'(1);
      noiseBlocks <= CFG_W'(1);
    end else if (cfgWrEn && !runEn) begin
      sampleCycles <= cfgSampleCycles;
      noiseBlocks <= cfgNoiseBlocks;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldCnt <= '0;
      bitCnt <= '0;
      byteCnt <= '0;
      blockCnt <= '0;
      groupDone <= 1'b0;
    end else if (!runEn) begin
      foldCnt <= '0;
      bitCnt <= '0;
      byteCnt <= '0;
      blockCnt <= '0;
      groupDone <= 1'b0;
    end else begin
      groupDone <= blockLast && (blockCnt == blockLim);
      if (strobes.foldLast) begin
        foldCnt <= '0;
        bitCnt <= bitCnt + BIT_CNT_W'(1);
      end else begin
        foldCnt <= foldCnt + FOLD_W'(1);
      end
      if (strobes.byteLast) byteCnt <= byteCnt + BYTE_CNT_W'(1);
      if (blockLast) begin
        if (blockCnt == blockLim) blockCnt <= '0;
        else blockCnt <= blockCnt + CFG_W'(1);
      end
    end
  end
endmodule

// File: rtl/esc_datapath.sv
module esc_datapath #(
  parameter int NUM_OSC = 24,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_OSC-1:0] oscIn,
  input  logic [NUM_OSC-1:0] oscMask,
  input  esc_pkg::escStrobes_t strobes,
  output logic byteValid,
  output logic [BYTE_W-1:0] byteOut
);
  logic [NUM_OSC-1:0] gated;
  logic parityBit;
  logic foldAcc;
  logic foldedBit;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;

  genvar g;
  generate
    for (g = 0; g < NUM_OSC; g++) begin : g_gate
      assign gated[g] = oscIn[g] & oscMask[g];
    end
  endgenerate

  always_comb begin
    parityBit = ^gated;
    foldedBit = foldAcc ^ parityBit;
    shiftNext = {shiftReg[BYTE_W-2:0], foldedBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldAcc <= 1'b0;
      shiftReg <= '0;
      byteValid <= 1'b0;
      byteOut <= '0;
    end else if (strobes.clear) begin
      foldAcc <= 1'b0;
      shiftReg <= '0;
      byteValid <= 1'b0;
    end else if (strobes.sample) begin
      byteValid <= strobes.byteLast;
      if (strobes.foldLast) begin
        foldAcc <= 1'b0;
        shiftReg <= shiftNext;
        if (strobes.byteLast) byteOut <= shiftNext;
      end else begin
        foldAcc <= foldedBit;
      end
    end
  end
endmodule

// File: rtl/entropy_sample_collector.sv
module entropy_sample_collector #(
  parameter int NUM_OSC = 24,
  parameter int CFG_W = 8,
  parameter int FOLD_W = 16,
  parameter int BLOCK_BITS = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic [NUM_OSC-1:0] oscIn,
  input  logic [NUM_OSC-1:0] oscMask,
  input  logic cfgWrEn,
  input  logic [CFG_W-1:0] cfgSampleCycles,
  input  logic [CFG_W-1:0] cfgNoiseBlocks,
  output logic byteValid,
  output logic [7:0] byteOut,
  output logic groupDone
);
  localparam int BYTE_W = 8;

  esc_pkg::escStrobes_t strobes;

  esc_ctrl #(
    .CFG_W(CFG_W), .FOLD_W(FOLD_W), .BLOCK_BITS(BLOCK_BITS), .BYTE_W(BYTE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWrEn(cfgWrEn),
    .cfgSampleCycles(cfgSampleCycles), .cfgNoiseBlocks(cfgNoiseBlocks),
    .strobes(strobes), .groupDone(groupDone)
  );

  esc_datapath #(
    .NUM_OSC(NUM_OSC), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .oscMask(oscMask),
    .strobes(strobes), .byteValid(byteValid), .byteOut(byteOut)
  );
endmodule

// File: rtl/esc_checker.sv
module esc_checker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic byteValid,
  input logic [7:0] byteOut,
  input logic groupDone
);
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    groupDone |=> !groupDone);
  a_r6_done_with_byte: assert property (@(posedge clk) disable iff (!rstN)
    groupDone |-> byteValid);
  a_r4_byte_holds: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteOut));
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!byteValid && !groupDone));
endmodule

bind entropy_sample_collector esc_checker chk_i (
  .clk(clk), .rstN(rstN), .runEn(runEn), .byteValid(byteValid),
  .byteOut(byteOut), .groupDone(groupDone)
);

// File: tb/entropy_sample_collector_tb_top.sv
module entropy_sample_collector_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [23:0] oscIn = '0;
  logic [23:0] oscMask = '0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgSampleCycles = '0;
  logic [7:0] cfgNoiseBlocks = '0;
  logic byteValid;
  logic [7:0] byteOut;
  logic groupDone;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  bit cmpOn = 0;
  int validSeen = 0;
  int doneSeen = 0;

  // reference model state
  int mSc = 1, mNb = 1, mFold = 0, mBytes = 0, mBlocks = 0;
  bit mAcc = 0;
  bit mBits[$];
  bit expValid = 0, expDone = 0;
  logic [7:0] expByte = '0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  entropy_sample_collector dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .oscIn(oscIn), .oscMask(oscMask),
    .cfgWrEn(cfgWrEn), .cfgSampleCycles(cfgSampleCycles),
    .cfgNoiseBlocks(cfgNoiseBlocks), .byteValid(byteValid), .byteOut(byteOut),
    .groupDone(groupDone)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mSc = 1; mNb = 1; mFold = 0; mBytes = 0; mBlocks = 0; mAcc = 0;
      mBits.delete(); expValid = 0; expDone = 0; expByte = '0;
    end else begin
      if (cfgWrEn && !runEn) begin
        mSc = cfgSampleCycles; mNb = cfgNoiseBlocks;
      end
      expValid = 0; expDone = 0;
      if (!runEn) begin
        mFold = 0; mBytes = 0; mBlocks = 0; mAcc = 0; mBits.delete();
      end else begin
        mAcc = mAcc ^ (^(oscIn & oscMask));
        mFold++;
        if (mFold == ((mSc == 0) ? 65536 : mSc)) begin
          mFold = 0;
          mBits.push_back(mAcc);
          mAcc = 0;
          if (mBits.size() == 8) begin
            for (int i = 0; i < 8; i++) expByte[7-i] = mBits[i];
            mBits.delete();
            expValid = 1;
            mBytes++;
            if (mBytes == 64) begin
              mBytes = 0;
              mBlocks++;
              if (mBlocks == ((mNb == 0) ? 256 : mNb)) begin
                mBlocks = 0;
                expDone = 1;
              end
            end
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare on every cycle, at the falling edge, before inputs change
  always @(negedge clk) begin
    cycles++;
    if (byteValid) validSeen++;
    if (groupDone) doneSeen++;
    if (cmpOn && rstN) begin
      check(byteValid == expValid, "R5 byteValid", byteValid, expValid);
      check(groupDone == expDone, "R6 groupDone", groupDone, expDone);
      check(byteOut == expByte, "R4 byteOut", byteOut, expByte);
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      oscIn = lfsr[23:0];
    end
  endtask

  task automatic configure(input int sc, input int nb);
    @(negedge clk); #1;
    runEn = 0; cfgWrEn = 1; cfgSampleCycles = 8'(sc); cfgNoiseBlocks = 8'(nb);
    step(1);
    cfgWrEn = 0;
  endtask

  initial begin
    step(3);
    // R1 reset state
    check(byteValid == 0, "R1 byteValid", byteValid, 0);
    check(groupDone == 0, "R1 groupDone", groupDone, 0);
    check(byteOut == 0, "R1 byteOut", byteOut, 0);
    rstN = 1;
    cmpOn = 1;
    // R1 default settings: fold 1, one block per group
    oscMask = '1; runEn = 1;
    validSeen = 0; doneSeen = 0;
    step(600);
    check(doneSeen == 1, "R1 R6 default group", doneSeen, 1);
    // R3 fold 3, R6 two blocks, single source R2
    configure(3, 2);
    oscMask = 24'h000020; runEn = 1;
    doneSeen = 0;
    step(3200);
    check(doneSeen == 1, "R6 two-block group", doneSeen, 1);
    // R7 write while running is ignored
    cfgWrEn = 1; cfgSampleCycles = 8'd7; cfgNoiseBlocks = 8'd5;
    step(2);
    cfgWrEn = 0;
    step(500);
    // R8 stop mid-byte, resume
    step(5);
    runEn = 0;
    step(3);
    runEn = 1;
    step(300);
    // R2 zero mask gives zero bytes
    runEn = 0; oscMask = '0; step(1); runEn = 1;
    step(200);
    check(byteOut == 0, "R2 zero mask", byteOut, 0);
    // R2 alternating mask
    oscMask = 24'hAAAAAA;
    step(400);
    // R3 fold length 0 means 65536
    configure(0, 1);
    oscMask = '1; runEn = 1; validSeen = 0;
    step(20000);
    check(validSeen == 0, "R3 zero fold length", validSeen, 0);
    // R6 group length 0 means 256 blocks
    configure(1, 0);
    oscMask = 24'h5A5A5A; runEn = 1; doneSeen = 0;
    step(131072 + 20);
    check(doneSeen == 1, "R6 zero group length", doneSeen, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule